// File: doc/BRIEF.md
# Firmware Hub Single-Byte Write Target

This block is a bus target for a 4-bit multiplexed firmware-hub bus. It follows the host one nibble per clock through a memory write cycle. First it sees a cycle-type nibble while the active-low frame strobe is low. Then it sees an identity-select nibble, compared against a strapped 4-bit device ID. Seven address nibbles follow, most significant first, then a transfer-size nibble, then two data nibbles, least significant first. The block rebuilds the 28-bit address and the data byte from these nibbles.

When the header is acceptable, the target takes the bus through a two-clock turnaround. It drives an all-zero ready-sync nibble for one clock, drives all ones for one clock, and then releases the bus back to the host. The full cycle lasts 17 clocks. In the ready-sync clock it raises a one-clock write strobe, and the assembled address and byte are valid on its outputs in that same clock. A wrong cycle type, a foreign ID or an unsupported size sends it back to idle without ever enabling its drivers. The frame strobe going low in the middle of a cycle aborts that cycle and begins a new one.

Top module: `fwh_wr_target`

## Requirements
- R1: A synchronous active-high reset, applied at any point of a cycle, returns the target to idle. While reset is applied and afterwards, bus_oe and wr_stb stay 0 until a new cycle starts.
- R2: A cycle begins on a clock where frame_n is low. If frame_n is low for several clocks, only the nibble on the last low clock counts as the cycle-type nibble.
- R3: The nibble on the first clock after frame_n rises is the identity select. If it differs from dev_id, the target never drives the bus and never strobes in that cycle.
- R4: Clocks 3 to 9 of the cycle carry the address. Clock 3 carries bits 27:24 and clock 9 carries bits 3:0. The strobed wr_addr equals these 28 bits.
- R5: Clock 10 carries the size nibble. Only 4'b0000 is accepted; any other value makes the target drop the cycle without driving or strobing.
- R6: Clock 11 carries data bits 3:0 and clock 12 carries data bits 7:4. The strobed wr_data equals this byte.
- R7: On an accepted cycle, with clock 1 being the last frame_n-low clock, bus_oe is 0 on clocks 1 to 13. On clocks 14, 15 and 16 it is 1, and bus_out is 4'hF, 4'h0 and 4'hF. On clock 17 bus_oe is 0 again.
- R8: wr_stb is high for exactly one clock per accepted cycle, on clock 15, together with the ready-sync nibble 4'h0 and valid wr_addr and wr_data.
- R9: If frame_n goes low during a cycle, bus_oe and wr_stb are 0 in that same clock. The old cycle produces no strobe, and that clock is treated as clock 1 of a new cycle.
- R10: A cycle-type nibble other than 4'b1101 is not a write. The target does not drive or strobe for it.
- R11: A new cycle may start on the clock right after clock 17 of the previous one and is handled in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low cycle frame strobe from the host |
| bus_in | input | 4 | Nibble currently on the shared bus |
| dev_id | input | 4 | Strapped identity this target answers to |
| bus_out | output | 4 | Nibble the target places on the bus when enabled |
| bus_oe | output | 1 | Output enable for the target's bus drivers |
| wr_stb | output | 1 | One-clock strobe marking an accepted write |
| wr_addr | output | 28 | Assembled write address, valid with wr_stb |
| wr_data | output | 8 | Assembled write byte, valid with wr_stb |

## Verification
A table of cycles is played back to back. The table contains accepted writes with different address and data patterns, and these tell a reversed or shifted nibble order apart in both the address and the byte. Each of the three header checks (cycle type, identity, size) is failed alone, which shows that every check is a separate gate on the drivers. Cycles with several low frame clocks separate "first start nibble" from "last start nibble". Directed runs then cut a cycle short with a new frame during the address phase and during the target's own drive window, and with reset, so that release timing and the absence of stale strobes can be seen.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] START_MEM_WRITE = 4'b1101;
    localparam logic [NIB_W-1:0] SIZE_SINGLE     = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_IDLE_HIGH   = 4'b1111;
    localparam logic [NIB_W-1:0] NIB_READY       = 4'b0000;

    // One state per bus phase; the counted phases share a counter.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FRAME,    // cycle-type nibble held; identity nibble on the bus
        ST_ADDR,     // address nibbles, most significant first
        ST_SIZE,
        ST_DATA,     // data nibbles, least significant first
        ST_HOST_TAR, // host drives ones then floats
        ST_GRAB,     // target takes the bus
        ST_SYNC,     // ready nibble, write strobe
        ST_DROP,     // target drives ones then floats
        ST_RETURN    // host takes the bus back
    } seq_st_e;

    typedef struct packed {
        logic             oe;
        logic [NIB_W-1:0] nib;
        logic             stb;
    } drive_s;

    function automatic logic header_ok(input logic [NIB_W-1:0] start_nib,
                                       input logic [NIB_W-1:0] id_nib,
                                       input logic [NIB_W-1:0] own_id);
        return (start_nib == START_MEM_WRITE) && (id_nib == own_id);
    endfunction

    function automatic drive_s phase_drive(input seq_st_e st);
        drive_s d;
        d.oe  = 1'b0;
        d.nib = NIB_IDLE_HIGH;
        d.stb = 1'b0;
        case (st)
            ST_GRAB: d.oe = 1'b1;
            ST_SYNC: begin
                d.oe  = 1'b1;
                d.nib = NIB_READY;
                d.stb = 1'b1;
            end
            ST_DROP: d.oe = 1'b1;
            default: d.oe = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fwh_seq.sv
module fwh_seq
    import fwh_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int DATA_NIBS = 2,
    localparam int CNT_MAX  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS,
    localparam int CNT_W    = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic [NIB_W-1:0] bus_in,
    input  logic [NIB_W-1:0] dev_id,
    output seq_st_e          state,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

    logic [NIB_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            start_q <= '0;
        end else if (!frame_n) begin
            // every low frame clock restarts; the last one wins
            state   <= ST_FRAME;
            cnt     <= '0;
            start_q <= bus_in;
        end else begin
            case (state)
                ST_FRAME: begin
                    cnt   <= '0;
                    state <= header_ok(start_q, bus_in, dev_id) ? ST_ADDR : ST_IDLE;
                end
                ST_ADDR: begin
                    if (cnt == ADDR_LAST) begin
                        cnt   <= '0;
                        state <= ST_SIZE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SIZE: begin
                    cnt   <= '0;
                    state <= (bus_in == SIZE_SINGLE) ? ST_DATA : ST_IDLE;
                end
                ST_DATA: begin
                    if (cnt == DATA_LAST) begin
                        cnt   <= '0;
                        state <= ST_HOST_TAR;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOST_TAR: state <= ST_GRAB;
                ST_GRAB:     state <= ST_SYNC;
                ST_SYNC:     state <= ST_DROP;
                ST_DROP:     state <= ST_RETURN;
                ST_RETURN:   state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    // header gate: entering the address phase needs a write type and our ID
    assert_header_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && cnt == '0) |->
            ($past(start_q) == START_MEM_WRITE && $past(bus_in) == $past(dev_id)))
        else $error("header accepted without write type and matching ID");

    // size phase is reached only after the full address run
    assert_addr_run_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SIZE) |-> ($past(state) == ST_ADDR && $past(cnt) == ADDR_LAST))
        else $error("size phase entered early");

    // data phase only follows a single-byte size nibble
    assert_size_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && cnt == '0) |->
            ($past(state) == ST_SIZE && $past(bus_in) == SIZE_SINGLE))
        else $error("data phase entered without single-byte size");

endmodule

// File: rtl/fwh_capture.sv
module fwh_capture
    import fwh_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int DATA_NIBS = 2,
    localparam int CNT_MAX  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS,
    localparam int CNT_W    = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1,
    localparam int ADDR_W   = ADDR_NIBS * NIB_W,
    localparam int DATA_W   = DATA_NIBS * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_st_e           state,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [NIB_W-1:0]  bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    // address: shift in at the bottom, so the first nibble ends on top
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (state == ST_ADDR) begin
            addr_q <= {addr_q[ADDR_W-NIB_W-1:0], bus_in};
        end
    end

    // data: each nibble lands in the slot named by its arrival index
    for (genvar g = 0; g < DATA_NIBS; g++) begin : g_data_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[g*NIB_W +: NIB_W] <= '0;
            end else if (state == ST_DATA && cnt == CNT_W'(g)) begin
                data_q[g*NIB_W +: NIB_W] <= bus_in;
            end
        end
    end

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state != ST_ADDR) |=> $stable(addr_q))
        else $error("address changed outside the address phase");

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_DATA) |=> $stable(data_q))
        else $error("data changed outside the data phase");

endmodule

// File: rtl/fwh_drive.sv
module fwh_drive
    import fwh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_st_e          state,
    input  logic             frame_n,
    output logic             bus_oe,
    output logic [NIB_W-1:0] bus_out,
    output logic             wr_stb
);

    drive_s ph;

    always_comb begin
        ph      = phase_drive(state);
        // a new frame takes the drivers off the bus in the same clock
        bus_oe  = ph.oe  && frame_n;
        wr_stb  = ph.stb && frame_n;
        bus_out = ph.nib;
    end

    assert_abort_release_R9: assert property (@(posedge clk) disable iff (rst)
        !frame_n |-> (!bus_oe && !wr_stb))
        else $error("drivers enabled while frame is low");

    assert_sync_nibble_R8: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (bus_oe && bus_out == NIB_READY))
        else $error("strobe without ready nibble on the bus");

    assert_take_ones_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> (bus_out == NIB_IDLE_HIGH))
        else $error("bus taken with a value other than all ones");

    assert_drop_after_sync_R7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (!frame_n || (bus_oe && bus_out == NIB_IDLE_HIGH)))
        else $error("ready nibble not followed by all-ones turnaround");

endmodule

// File: rtl/fwh_wr_target.sv
module fwh_wr_target
    import fwh_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int DATA_NIBS = 2,
    localparam int CNT_MAX  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS,
    localparam int CNT_W    = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1,
    localparam int ADDR_W   = ADDR_NIBS * NIB_W,
    localparam int DATA_W   = DATA_NIBS * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    input  logic [3:0]        dev_id,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    seq_st_e          state;
    logic [CNT_W-1:0] cnt;

    fwh_seq #(
        .ADDR_NIBS(ADDR_NIBS),
        .DATA_NIBS(DATA_NIBS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .bus_in  (bus_in),
        .dev_id  (dev_id),
        .state   (state),
        .cnt     (cnt)
    );

    fwh_capture #(
        .ADDR_NIBS(ADDR_NIBS),
        .DATA_NIBS(DATA_NIBS)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .cnt    (cnt),
        .bus_in (bus_in),
        .addr_q (wr_addr),
        .data_q (wr_data)
    );

    fwh_drive u_drv (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .frame_n (frame_n),
        .bus_oe  (bus_oe),
        .bus_out (bus_out),
        .wr_stb  (wr_stb)
    );

    // one strobe per cycle: never two clocks in a row
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb)
        else $error("write strobe longer than one clock");

endmodule

// File: tb/tb_fwh_wr_target.sv
module tb_fwh_wr_target;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic [3:0]  bus_in = 4'hF;
    logic [3:0]  dev_id = 4'hA;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic        wr_stb;
    logic [27:0] wr_addr;
    logic [7:0]  wr_data;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    fwh_wr_target dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .bus_in(bus_in), .dev_id(dev_id),
        .bus_out(bus_out), .bus_oe(bus_oe), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    typedef struct packed {
        logic [3:0]  dev;
        logic [3:0]  start;
        logic [3:0]  id;
        logic [27:0] addr;
        logic [3:0]  size;
        logic [7:0]  data;
        logic [1:0]  pre;   // extra low frame clocks before the real one
        logic [3:0]  pnib;  // nibble on those extra clocks
        logic        ack;   // expected acknowledge
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{4'hA, 4'hD, 4'hA, 28'h1234567, 4'h0, 8'h5C, 2'd0, 4'h0, 1'b1},
        '{4'hA, 4'hD, 4'hA, 28'hFEDCBA9, 4'h0, 8'hA3, 2'd2, 4'h0, 1'b1},
        '{4'hA, 4'hD, 4'h3, 28'h0000001, 4'h0, 8'h11, 2'd0, 4'h0, 1'b0},
        '{4'hA, 4'hC, 4'hA, 28'h0ABCDEF, 4'h0, 8'h22, 2'd0, 4'h0, 1'b0},
        '{4'hA, 4'hD, 4'hA, 28'h7654321, 4'h1, 8'h33, 2'd0, 4'h0, 1'b0},
        '{4'h5, 4'hD, 4'h5, 28'h8000000, 4'h0, 8'hFF, 2'd0, 4'h0, 1'b1},
        '{4'h5, 4'hD, 4'hA, 28'h0F0F0F0, 4'h0, 8'h44, 2'd0, 4'h0, 1'b0},
        '{4'hA, 4'hD, 4'hA, 28'h0000000, 4'h0, 8'h01, 2'd1, 4'hD, 1'b1},
        '{4'hA, 4'h0, 4'hA, 28'h1111111, 4'h0, 8'h80, 2'd3, 4'hD, 1'b0},
        '{4'hA, 4'hD, 4'hA, 28'hC3A5968, 4'h8, 8'h96, 2'd0, 4'h0, 1'b0}
    };

    function automatic logic [3:0] nib_at(input int k, input logic [3:0] start,
            input logic [3:0] id, input logic [27:0] addr,
            input logic [3:0] size, input logic [7:0] data);
        if (k == 1) return start;
        if (k == 2) return id;
        if (k >= 3 && k <= 9) return addr[(9-k)*4 +: 4];
        if (k == 10) return size;
        if (k == 11) return data[3:0];
        if (k == 12) return data[7:4];
        return 4'hF;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // observation record of one played clock
    logic        o_oe;
    logic [3:0]  o_out;
    logic        o_stb;
    logic [27:0] o_addr;
    logic [7:0]  o_data;

    task automatic play(input logic fr, input logic [3:0] nib);
        @(negedge clk);
        frame_n = fr;
        bus_in  = nib;
        #1;
        o_oe   = bus_oe;
        o_out  = bus_out;
        o_stb  = wr_stb;
        o_addr = wr_addr;
        o_data = wr_data;
    endtask

    logic first_oe;  // drivers as seen on clock 1 of the last played cycle

    task automatic do_write(input logic [3:0] start, input logic [3:0] id,
            input logic [27:0] addr, input logic [3:0] size, input logic [7:0] data,
            input int pre, input logic [3:0] pnib, input logic ack, input string req);
        logic [16:0] oe_act, oe_exp;
        logic [67:0] out_act, out_exp;
        logic [16:0] stb_act, stb_exp;
        logic [27:0] got_addr = '0;
        logic [7:0]  got_data = '0;
        for (int p = 0; p < pre; p++) play(1'b0, pnib);
        oe_act = '0; out_act = '0; stb_act = '0;
        oe_exp = '0; out_exp = '0; stb_exp = '0;
        for (int k = 1; k <= 17; k++) begin
            play(k == 1 ? 1'b0 : 1'b1, nib_at(k, start, id, addr, size, data));
            if (k == 1) first_oe = o_oe;
            oe_act[k-1]  = o_oe;
            stb_act[k-1] = o_stb;
            if (o_oe) out_act[(k-1)*4 +: 4] = o_out;
            if (o_stb) begin
                got_addr = o_addr;
                got_data = o_data;
            end
        end
        if (ack) begin
            oe_exp[13] = 1'b1; oe_exp[14] = 1'b1; oe_exp[15] = 1'b1;
            out_exp[13*4 +: 4] = 4'hF;
            out_exp[14*4 +: 4] = 4'h0;
            out_exp[15*4 +: 4] = 4'hF;
            stb_exp[14] = 1'b1;
        end
        // response (accepted or ignored) as decided by the header fields
        check((|oe_act) == ack, req, "acknowledge decision", 64'(|oe_act), 64'(ack));
        check(oe_act == oe_exp, "R7", "driver enable per clock", 64'(oe_act), 64'(oe_exp));
        if (ack) begin
            check(out_act == out_exp, "R7", "driven nibbles", out_act[63:0], out_exp[63:0]);
            check(stb_act == stb_exp, "R8", "strobe clock", 64'(stb_act), 64'(stb_exp));
            check(got_addr == addr, "R4", "write address", 64'(got_addr), 64'(addr));
            check(got_data == data, "R6", "write data", 64'(got_data), 64'(data));
        end else begin
            check(stb_act == '0, req, "no strobe on ignored cycle", 64'(stb_act), 64'h0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        string req;
        logic  any_oe;
        logic  any_stb;
        // reset state (R1)
        repeat (2) @(negedge clk);
        #1;
        check(!bus_oe && !wr_stb, "R1", "outputs during reset", {bus_oe, wr_stb}, 64'h0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!bus_oe && !wr_stb, "R1", "outputs after reset", {bus_oe, wr_stb}, 64'h0);

        // table of cycles, back to back (R11 by consecution)
        for (int i = 0; i < NVEC; i++) begin
            dev_id = VEC[i].dev;
            if (VEC[i].pre != 0)                 req = "R2";
            else if (VEC[i].id != VEC[i].dev)    req = "R3";
            else if (VEC[i].start != 4'hD)       req = "R10";
            else if (VEC[i].size != 4'h0)        req = "R5";
            else                                 req = "R11";
            do_write(VEC[i].start, VEC[i].id, VEC[i].addr, VEC[i].size, VEC[i].data,
                     int'(VEC[i].pre), VEC[i].pnib, VEC[i].ack, req);
        end
        dev_id = 4'hA;

        // abort during address phase (R9)
        for (int k = 1; k <= 5; k++)
            play(k == 1 ? 1'b0 : 1'b1, nib_at(k, 4'hD, 4'hA, 28'h9999999, 4'h0, 8'h77));
        do_write(4'hD, 4'hA, 28'h2468ACE, 4'h0, 8'hE1, 0, 4'h0, 1'b1, "R9");

        // abort inside the target's drive window (R9)
        for (int k = 1; k <= 14; k++)
            play(k == 1 ? 1'b0 : 1'b1, nib_at(k, 4'hD, 4'hA, 28'h5555555, 4'h0, 8'h66));
        check(o_oe && o_out == 4'hF, "R7", "drivers on at clock 14 before abort",
              {o_oe, o_out}, 64'h1F);
        do_write(4'hD, 4'hA, 28'h1357BDF, 4'h0, 8'h3C, 0, 4'h0, 1'b1, "R9");
        check(!first_oe, "R9", "drivers released on abort clock", 64'(first_oe), 64'h0);

        // reset in the middle of an accepted cycle (R1)
        for (int k = 1; k <= 13; k++)
            play(k == 1 ? 1'b0 : 1'b1, nib_at(k, 4'hD, 4'hA, 28'h0C0FFEE, 4'h0, 8'h42));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        any_oe = 1'b0;
        any_stb = 1'b0;
        for (int k = 0; k < 4; k++) begin
            play(1'b1, 4'hF);
            any_oe  = any_oe | o_oe;
            any_stb = any_stb | o_stb;
        end
        check(!any_oe && !any_stb, "R1", "no drive or strobe after mid-cycle reset",
              {any_oe, any_stb}, 64'h0);

        // target still works after that reset
        do_write(4'hD, 4'hA, 28'hBADCAFE, 4'h0, 8'hC7, 0, 4'h0, 1'b1, "R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule